// File: doc/BRIEF.md
# Banked Unaligned Multi-Word Fetch Memory

This is an instruction memory for a wide fetch stage. Each access returns `LANES` consecutive 32-bit instruction words that start at any word address. The start address does not have to be a multiple of `LANES`. Storage is spread across `LANES` independent banks. Consecutive word addresses fall into consecutive banks, so any run of `LANES` adjacent words touches every bank exactly once. Each bank receives its own row index, and the bank outputs are rotated so that the word at the requested address leaves on lane 0.

A request is a word address qualified by a valid bit. The response appears exactly one clock later: a valid bit and a flat vector of `LANES` words. A separate single-word write port loads program images and patches the memory. There is no miss path and no byte access. `LANES` and `ROWS` must both be powers of two, and `LANES` must be at least 2.

Top module: `fetchMemTop`

## Requirements
- R1: While reset is asserted (`rstN` low) and in the first cycle after it, `rspValid` is 0.
- R2: `rspValid` is 1 in the cycle after a cycle in which `reqValid` was 1, and 0 in the cycle after a cycle in which `reqValid` was 0.
- R3: For a request address that is a multiple of `LANES`, lane j (bits j*32 +: 32 of `rspWords`) carries the word stored at address addr+j.
- R4: For a request address that is not a multiple of `LANES`, lane j still carries the word at addr+j. Lanes beyond the end of the current row take their words from the next row of the lower banks. With LANES=4, address 5 returns words 5,6,7,8.
- R5: A word written through the write port (`wrEn`=1, `wrAddr`, `wrData`) is returned by any later read whose window of `LANES` words covers that address. It appears on lane (wrAddr − reqAddr) mod (LANES·ROWS).
- R6: Addresses wrap at the top of memory. A read starting within the last `LANES`−1 words continues from word 0, 1, … on the higher lanes.
- R7: When a read and a write to a word inside the read window happen in the same cycle, the response carries the value held before the write. The next read carries the new value.
- R8: While `reqValid` is 0, `rspWords` keeps the last response unchanged, even if the write port updates the words it shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request strobe |
| reqAddr | input | ADDR_W (8) | Word address of lane 0 of the read |
| wrEn | input | 1 | Write port enable |
| wrAddr | input | ADDR_W (8) | Word address to write |
| wrData | input | 32 | Word to write |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspWords | output | LANES*32 (128) | Response words, lane j at bits j*32 +: 32 |

## Verification
Assertions check several properties on every cycle: the one-cycle valid latency, and that the number of banks stepping to the next row equals the address offset within a row. They also check that a freshly written word is read back on lane 0, and that the lanes stay frozen while no request is made. The bench alone can show the full contents of each lane against a model of memory. This covers aligned and unaligned windows, wrap at the top of memory, and the old-data result of a read that collides with a write.

// File: rtl/fetchMemPkg.sv
package fetchMemPkg;
  // Strobes from the control to the bank datapath.
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } memStrobe_t;
endpackage

// File: rtl/fetchMemCtl.sv
module fetchMemCtl
  import fetchMemPkg::*;
#(
  parameter int LANES  = 4,
  parameter int ROWS   = 64,
  parameter int ADDR_W = 8,
  parameter int LANE_W = 2,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output memStrobe_t        strobe,
  output logic [ROW_W-1:0]  rowSel [LANES],
  output logic [LANE_W-1:0] wrBank,
  output logic [ROW_W-1:0]  wrRow,
  output logic [LANE_W-1:0] rotReg,
  output logic              rspValid
);
  logic [ROW_W-1:0]  baseRow;
  logic [LANE_W-1:0] offset;
  logic [LANES-1:0]  useNext;

  assign baseRow = reqAddr[ADDR_W-1:LANE_W];
  assign offset  = reqAddr[LANE_W-1:0];
  assign wrBank  = wrAddr[LANE_W-1:0];
  assign wrRow   = wrAddr[ADDR_W-1:LANE_W];

  assign strobe.rdEn = reqValid;
  assign strobe.wrEn = wrEn;

  // Banks below the start offset hold words that belong to the next row.
  // The row index wraps naturally at ROWS, since ROWS is a power of two.
  for (genvar b = 0; b < LANES; b++) begin : gRow
    assign useNext[b] = (LANE_W'(b) < offset);
    assign rowSel[b]  = baseRow + ROW_W'(useNext[b]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rotReg   <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) rotReg <= offset;
    end
  end

  // The count of banks reading the following row must match the in-row offset.
  assert_next_row_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ($countones(useNext) == int'(offset)));
endmodule

// File: rtl/fetchMemBanks.sv
module fetchMemBanks
  import fetchMemPkg::*;
#(
  parameter int LANES  = 4,
  parameter int ROWS   = 64,
  parameter int WORD_W = 32,
  parameter int LANE_W = 2,
  parameter int ROW_W  = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  memStrobe_t              strobe,
  input  logic [ROW_W-1:0]        rowSel [LANES],
  input  logic [LANE_W-1:0]       wrBank,
  input  logic [ROW_W-1:0]        wrRow,
  input  logic [WORD_W-1:0]       wrData,
  input  logic [LANE_W-1:0]       rotReg,
  output logic [LANES*WORD_W-1:0] rspWords
);
  logic [WORD_W-1:0] bankOut [LANES];

  for (genvar b = 0; b < LANES; b++) begin : gBank
    logic [WORD_W-1:0] store [ROWS];
    logic [WORD_W-1:0] rdq;

    always_ff @(posedge clk) begin
      if (strobe.wrEn && (wrBank == LANE_W'(b))) store[wrRow] <= wrData;
      if (strobe.rdEn) rdq <= store[rowSel[b]];
    end

    assign bankOut[b] = rdq;
  end

  // Rotate the bank outputs so that lane j shows address+j.
  for (genvar j = 0; j < LANES; j++) begin : gLane
    logic [LANE_W-1:0] srcBank;
    assign srcBank = rotReg + LANE_W'(j);
    assign rspWords[j*WORD_W +: WORD_W] = bankOut[srcBank];
  end

  // With no read issued, the lanes must not move.
  assert_lanes_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rspWords));
endmodule

// File: rtl/fetchMemTop.sv
module fetchMemTop
  import fetchMemPkg::*;
#(
  parameter int  LANES  = 4,
  parameter int  ROWS   = 64,
  parameter int  WORD_W = 32,
  localparam int LANE_W = $clog2(LANES),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = LANE_W + ROW_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [WORD_W-1:0]       wrData,
  output logic                    rspValid,
  output logic [LANES*WORD_W-1:0] rspWords
);
  memStrobe_t        strobe;
  logic [ROW_W-1:0]  rowSel [LANES];
  logic [LANE_W-1:0] wrBank;
  logic [ROW_W-1:0]  wrRow;
  logic [LANE_W-1:0] rotReg;

  fetchMemCtl #(
    .LANES(LANES), .ROWS(ROWS), .ADDR_W(ADDR_W), .LANE_W(LANE_W), .ROW_W(ROW_W)
  ) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe), .rowSel(rowSel),
    .wrBank(wrBank), .wrRow(wrRow), .rotReg(rotReg), .rspValid(rspValid)
  );

  fetchMemBanks #(
    .LANES(LANES), .ROWS(ROWS), .WORD_W(WORD_W), .LANE_W(LANE_W), .ROW_W(ROW_W)
  ) uBanks (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rowSel(rowSel),
    .wrBank(wrBank), .wrRow(wrRow), .wrData(wrData), .rotReg(rotReg),
    .rspWords(rspWords)
  );

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_valid_drops_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // A word written one cycle before a read that starts at it shows on lane 0.
  assert_write_visible_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && $past(wrEn) && (reqAddr == $past(wrAddr)))
      |=> (rspWords[WORD_W-1:0] == $past(wrData, 2)));
endmodule

// File: tb/sim_fetchMemTop.sv
`timescale 1ns/1ps
module sim_fetchMemTop;
  localparam int LANES  = 4;
  localparam int ROWS   = 64;
  localparam int WORD_W = 32;
  localparam int TOTAL  = LANES * ROWS;
  localparam int ADDR_W = $clog2(TOTAL);

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    reqValid = 1'b0;
  logic [ADDR_W-1:0]       reqAddr = '0;
  logic                    wrEn = 1'b0;
  logic [ADDR_W-1:0]       wrAddr = '0;
  logic [WORD_W-1:0]       wrData = '0;
  logic                    rspValid;
  logic [LANES*WORD_W-1:0] rspWords;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  logic [WORD_W-1:0] model [TOTAL];

  fetchMemTop #(.LANES(LANES), .ROWS(ROWS), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rspValid(rspValid), .rspWords(rspWords)
  );

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [LANES*WORD_W-1:0] expLanes(int a);
    logic [LANES*WORD_W-1:0] v;
    for (int j = 0; j < LANES; j++) v[j*WORD_W +: WORD_W] = model[(a + j) % TOTAL];
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [LANES*WORD_W-1:0] act,
                       logic [LANES*WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeWord(int a, logic [WORD_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = d;
    model[a] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Issue one read and check all lanes plus valid at the next negedge.
  task automatic readCheck(int a, string req);
    logic [LANES*WORD_W-1:0] e;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = ADDR_W'(a);
    e = expLanes(a);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid === 1'b1 && rspWords === e, req, rspWords, e);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [LANES*WORD_W-1:0] held;
    logic [LANES*WORD_W-1:0] e;
    logic [WORD_W-1:0] oldW;
    void'($urandom(32'h5eed_0042));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(rspValid === 1'b0, "R1", {127'b0, rspValid}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid === 1'b0, "R1", {127'b0, rspValid}, '0);

    // Preload memory through the write port.
    for (int w = 0; w < TOTAL; w++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = ADDR_W'(w); wrData = $urandom;
      model[w] = wrData;
    end
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);

    // R3: aligned windows
    readCheck(0, "R3");
    readCheck(8, "R3");
    readCheck(TOTAL - LANES, "R3");

    // R4: unaligned windows, every offset
    readCheck(5, "R4");
    readCheck(6, "R4");
    readCheck(7, "R4");
    readCheck(133, "R4");

    // R2: valid drops one cycle after an idle request cycle
    @(negedge clk);
    check(rspValid === 1'b0, "R2", {127'b0, rspValid}, '0);

    // R6: wrap at the top of memory
    readCheck(TOTAL - 1, "R6");
    readCheck(TOTAL - 2, "R6");
    readCheck(TOTAL - 3, "R6");

    // R5: patch a word, then read windows that cover it from several starts
    writeWord(42, 32'hCAFE_0042);
    readCheck(42, "R5");
    readCheck(40, "R5");
    readCheck(39, "R5");
    writeWord(0, 32'hBEEF_0000);
    readCheck(TOTAL - 2, "R5");

    // R7: same-cycle read and write to a word in the window
    @(negedge clk);
    e = expLanes(21);
    oldW = model[22];
    reqValid = 1'b1; reqAddr = ADDR_W'(21);
    wrEn = 1'b1; wrAddr = ADDR_W'(22); wrData = 32'h1234_5678;
    @(negedge clk);
    reqValid = 1'b0; wrEn = 1'b0;
    model[22] = 32'h1234_5678;
    check(rspWords === e && rspWords[WORD_W +: WORD_W] === oldW, "R7", rspWords, e);
    readCheck(21, "R7");

    // R8: response held while idle, even across a write to a shown word
    held = rspWords;
    writeWord(23, 32'h0BAD_F00D);
    @(negedge clk);
    check(rspWords === held, "R8", rspWords, held);

    // Random reads with occasional writes
    for (int i = 0; i < 400; i++) begin
      int a;
      a = int'($urandom % TOTAL);
      if (($urandom % 4) == 0) writeWord(int'($urandom % TOTAL), $urandom);
      readCheck(a, (a % LANES == 0) ? "R3" : "R4");
      if (($urandom % 3) == 0) begin
        held = rspWords;
        @(negedge clk);
        check(rspValid === 1'b0 && rspWords === held, "R8", rspWords, held);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule